// File: doc/BRIEF.md
# Port-Mapped Random Byte Generator

This block returns a fresh pseudo-random byte each time the bus reads one fixed I/O address. No index register has to be written first. The state is a 32-bit linear feedback shift register. On every read it moves forward several bit positions in a single cycle, so neighbouring output bytes are not shifted copies of each other.

Real entropy comes from a free-running counter clocked by an unrelated clock. The counter crosses into the bus clock domain as a Gray code through a two-flop synchroniser. Its low byte is folded into the register only on a decimated schedule: every fourth or every eighth read, chosen by a parameter. Reads in between cost nothing beyond the register advance.

Top module: `rng_port_top`

## Requirements
- R1: After reset `rd_data` is 0x00 and `rd_valid` is 0. The register state starts at the nonzero seed 0x1D0F_6B35 and the decimation count starts at zero.
- R2: A read takes effect only when `bus_rd` is 1 and `bus_addr` equals `PORT_ADDR` (default 0x02A7) in the same cycle. Any other combination leaves the state, the decimation count and `rd_data` unchanged, and `rd_valid` stays 0.
- R3: Each accepted read advances the register by `LFSR_STEPS` (default 8) single steps. One step shifts the 32-bit state left by one position and puts into bit 0 the XOR of bits 31, 21, 1 and 0 of the previous state.
- R4: `rd_data` shows bits [7:0] of the updated state in the cycle after the accepted read, and `rd_valid` is 1 in exactly that cycle. Between reads `rd_data` holds its value.
- R5: Reads are numbered from 1 after reset. Only reads number DECIM, 2*DECIM, and so on mix in entropy. For such a read, the synchronised entropy byte is XORed into bits [7:0] of the state after the advance.
- R6: Once the entropy clock has been quiet for at least four bus clock cycles, the entropy byte equals the number of entropy clock rising edges since the entropy reset, modulo 256.
- R7: The state is never all-zero. If the advance and mixing give zero, the seed is loaded instead.
- R8: `DECIM` accepts 4 or 8, and the injection period follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ent_clk | input | 1 | Unrelated clock that drives the entropy counter |
| ent_rst_n | input | 1 | Active-low asynchronous reset, entropy domain |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | I/O address of the read |
| rd_data | output | 8 | Random byte |
| rd_valid | output | 1 | Pulses in the cycle after an accepted read |

## Verification
The bench predicts every byte from a shadow register that uses its own mask-and-parity feedback. It runs one instance with DECIM 8 and one with DECIM 4 side by side, so an injection placed one read early or late, or applied before the advance instead of after it, shows up as a byte mismatch at the exact read concerned. Reads to neighbouring addresses, and a matching address with no strobe, are aimed at a decoder that lets them through: such a design would advance the state or pulse `rd_valid`, and every later byte would then disagree. Back-to-back reads and known counts of entropy edges check that the synchronised byte is the edge count, that a single-step or wrong-tap register diverges at once, and that the bytes stay stable while the bus is idle.

// File: rtl/rng_pkg.sv
package rng_pkg;

  localparam int LFSR_W = 32;
  localparam int MAX_STEPS = 32;

  // one shift of the 32-bit register, feedback from bits 31,21,1,0
  function automatic logic [LFSR_W-1:0] lfsr_one(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // n shifts unrolled into one combinational stage
  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s,
                                                  input int n);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < MAX_STEPS; i++) begin
      if (i < n) t = lfsr_one(t);
    end
    return t;
  endfunction

endpackage

// File: rtl/rng_entropy_src.sv
module rng_entropy_src #(
  parameter int W = 8
) (
  input  logic         ent_clk,
  input  logic         ent_rst_n,
  output logic [W-1:0] gray_q
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge ent_clk or negedge ent_rst_n) begin
    if (!ent_rst_n) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      gray_q <= cnt_nxt ^ (cnt_nxt >> 1);
    end
  end
endmodule

// File: rtl/rng_gray_sync.sv
module rng_gray_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/rng_decimator.sv
module rng_decimator #(
  parameter int DECIM = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic inject,
  output logic [$clog2(DECIM)-1:0] cnt_q
);
  localparam int CNT_W = $clog2(DECIM);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

  generate
    if (DECIM != 4 && DECIM != 8) begin : g_bad_decim
      $error("DECIM must be 4 or 8");
    end
  endgenerate

  assign inject = hit && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rng_lfsr_core.sv
module rng_lfsr_core
  import rng_pkg::*;
#(
  parameter int                 STEPS = 8,
  parameter logic [LFSR_W-1:0]  SEED  = 32'h1D0F_6B35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              inject,
  input  logic [7:0]        mix_byte,
  output logic [LFSR_W-1:0] state_q,
  output logic [LFSR_W-1:0] next_o,
  output logic              zero_fix
);
  logic [LFSR_W-1:0] stepped;
  logic [LFSR_W-1:0] mixed;

  assign stepped  = lfsr_adv(state_q, STEPS);
  assign mixed    = stepped ^ {{(LFSR_W-8){1'b0}}, (inject ? mix_byte : 8'h00)};
  assign zero_fix = (mixed == '0);
  assign next_o   = zero_fix ? SEED : mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= next_o;
    end
  end
endmodule

// File: rtl/rng_port_top.sv
module rng_port_top
  import rng_pkg::*;
#(
  parameter int                 ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]  PORT_ADDR  = 16'h02A7,
  parameter int                 DECIM      = 8,
  parameter int                 LFSR_STEPS = 8,
  parameter int                 ENT_W      = 8,
  parameter logic [LFSR_W-1:0]  SEED       = 32'h1D0F_6B35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_clk,
  input  logic              ent_rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int CNT_W = $clog2(DECIM);

  logic              hit;
  logic              inject;
  logic [CNT_W-1:0]  read_cnt;
  logic [ENT_W-1:0]  ent_gray;
  logic [ENT_W-1:0]  ent_bin;
  logic [7:0]        ent_byte;
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] state_nxt;
  logic              zero_fix;

  assign hit      = bus_rd && (bus_addr == PORT_ADDR);
  assign ent_byte = ent_bin[7:0];

  rng_entropy_src #(.W(ENT_W)) u_src (
    .ent_clk   (ent_clk),
    .ent_rst_n (ent_rst_n),
    .gray_q    (ent_gray)
  );

  rng_gray_sync #(.W(ENT_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .gray_in (ent_gray),
    .bin_out (ent_bin)
  );

  rng_decimator #(.DECIM(DECIM)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .inject (inject),
    .cnt_q  (read_cnt)
  );

  rng_lfsr_core #(.STEPS(LFSR_STEPS), .SEED(SEED)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (hit),
    .inject   (inject),
    .mix_byte (ent_byte),
    .state_q  (state),
    .next_o   (state_nxt),
    .zero_fix (zero_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= hit;
      if (hit) rd_data <= state_nxt[7:0];
    end
  end
endmodule

// File: rtl/rng_port_checker.sv
module rng_port_checker
  import rng_pkg::*;
#(
  parameter int DECIM      = 8,
  parameter int LFSR_STEPS = 8,
  parameter logic [LFSR_W-1:0] SEED = 32'h1D0F_6B35
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hit,
  input logic                       inject,
  input logic [$clog2(DECIM)-1:0]   read_cnt,
  input logic [LFSR_W-1:0]          state,
  input logic                       zero_fix,
  input logic [7:0]                 rd_data,
  input logic                       rd_valid
);
  p_valid_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rd_valid);

  p_no_valid_without_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !rd_valid);

  p_data_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  p_state_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(state));

  p_state_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  p_zero_gives_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && zero_fix) |=> state == SEED);

  p_plain_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !inject) |=> state == lfsr_adv($past(state), LFSR_STEPS));

  p_inject_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> read_cnt == '0);

  p_output_is_low_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == state[7:0]);
endmodule

bind rng_port_top rng_port_checker #(
  .DECIM(DECIM), .LFSR_STEPS(LFSR_STEPS), .SEED(SEED)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit      (hit),
  .inject   (inject),
  .read_cnt (read_cnt),
  .state    (state),
  .zero_fix (zero_fix),
  .rd_data  (rd_data),
  .rd_valid (rd_valid)
);

// File: tb/rng_port_top_test.sv
`timescale 1ns/1ps
module rng_port_top_test;
  localparam logic [15:0] PORT = 16'h02A7;
  localparam logic [31:0] SEED = 32'h1D0F_6B35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_clk = 1'b0;
  logic ent_rst_n = 1'b0;
  logic bus_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0] d8, d4;
  logic v8, v4;

  int checks = 0;
  int fails = 0;
  int ent_edges = 0;
  logic [31:0] m8, m4;
  int n8, n4;

  always #2.5 clk = ~clk;

  rng_port_top #(.DECIM(8)) uut (
    .clk(clk), .rst_n(rst_n), .ent_clk(ent_clk), .ent_rst_n(ent_rst_n),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .rd_data(d8), .rd_valid(v8));

  rng_port_top #(.DECIM(4)) uut4 (
    .clk(clk), .rst_n(rst_n), .ent_clk(ent_clk), .ent_rst_n(ent_rst_n),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .rd_data(d4), .rd_valid(v4));

  // shadow register: feedback as parity of masked taps
  function automatic logic [31:0] model_next(logic [31:0] s, bit inj, logic [7:0] e);
    logic [31:0] t = s;
    for (int k = 0; k < 8; k++) t = {t[30:0], ^(t & 32'h8020_0003)};
    if (inj) t = t ^ {24'h0, e};
    if (t == 32'h0) t = SEED;
    return t;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ent_pulses(int n);
    for (int i = 0; i < n; i++) begin
      #1.3 ent_clk = 1'b1;
      #1.7 ent_clk = 1'b0;
      ent_edges++;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic advance_models();
    bit i8, i4;
    n8++; n4++;
    i8 = (n8 % 8) == 0;
    i4 = (n4 % 4) == 0;
    m8 = model_next(m8, i8, ent_edges[7:0]);
    m4 = model_next(m4, i4, ent_edges[7:0]);
  endtask

  // one accepted read, sampled on the following falling edge
  task automatic port_read(string req);
    @(negedge clk);
    bus_addr = PORT; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    advance_models();
    chk(v8 && d8 == m8[7:0], req, {23'h0, v8, d8}, {24'h1, m8[7:0]});
    chk(v4 && d4 == m4[7:0], {req, " DECIM4 R8"}, {23'h0, v4, d4}, {24'h1, m4[7:0]});
  endtask

  task automatic back_to_back(int n);
    @(negedge clk);
    bus_addr = PORT; bus_rd = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) bus_rd = 1'b0;
      advance_models();
      chk(v8 && d8 == m8[7:0], "R3 R4 back-to-back", {23'h0, v8, d8}, {24'h1, m8[7:0]});
      chk(v4 && d4 == m4[7:0], "R8 back-to-back", {23'h0, v4, d4}, {24'h1, m4[7:0]});
    end
  endtask

  // strobe or address wrong: nothing may change (R2)
  task automatic ignored_access(logic rd, logic [15:0] addr);
    logic [7:0] h8, h4;
    @(negedge clk);
    h8 = d8; h4 = d4;
    bus_addr = addr; bus_rd = rd;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(!v8 && !v4 && d8 == h8 && d4 == h4, "R2 ignored access",
        {14'h0, v8, v4, d8, d4}, {16'h0, h8, h4});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m8 = SEED; m4 = SEED; n8 = 0; n4 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ent_rst_n = 1'b1;
    @(negedge clk);
    chk(d8 == 8'h00 && !v8 && d4 == 8'h00 && !v4, "R1 reset outputs",
        {14'h0, v8, v4, d8, d4}, 32'h0);

    port_read("R1 first byte from seed");
    for (int i = 0; i < 6; i++) port_read("R3 advance without entropy");

    ent_pulses(37);
    port_read("R5 R6 eighth read mixes edge count");
    for (int i = 0; i < 7; i++) port_read("R5 no mix between injections");
    port_read("R5 R6 sixteenth read mixes");

    ignored_access(1'b1, PORT ^ 16'h0001);
    ignored_access(1'b1, PORT ^ 16'h8000);
    ignored_access(1'b0, PORT);
    port_read("R2 state unchanged by ignored accesses");

    repeat (4) @(negedge clk);
    chk(!v8 && d8 == m8[7:0], "R4 data holds while idle", {23'h0, v8, d8}, {24'h0, m8[7:0]});

    ent_pulses(219);
    back_to_back(10);
    ent_pulses(256);
    back_to_back(9);

    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) ent_pulses($urandom_range(1, 40));
      else if (sel == 1) ignored_access($urandom_range(0, 1), 16'($urandom()) | 16'h1000);
      else if (sel == 2) back_to_back($urandom_range(2, 5));
      else port_read("R3 R5 R7 random read stream");
    end

    chk(m8 != 32'h0 && m4 != 32'h0, "R7 state never zero", m8, SEED);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule